// File: doc/BRIEF.md
# Timer Time-Base Prescaler with Pin Sampler

This block produces the shared count-enable strobe for a group of timer/counters and a watchdog. A 4-bit rate value sets how often the strobe fires. A value of N gives one strobe every N+1 system clocks, so the range runs from every clock down to every sixteenth clock. A separate timer-2 enable output either follows the shared strobe or stays high on every clock. The second case serves the third timer when it runs as a clock generator or baud generator, so that timer ignores the rate value.

The block also conditions six external pins: three counter inputs, one capture input and two interrupt requests. Each pin passes through a two-flop synchroniser. The block then samples each pin, keeps its last sampled level and raises a one-clock flag when a sample falls from 1 to 0.

A mode input picks one of two behaviours. It is captured only while reset is asserted:
- In compatibility mode the rate value resets to 5, which is one strobe per six-clock machine cycle, and the pins are sampled only on strobes.
- In fast mode the rate value resets to 0, and the pins are sampled on every clock whatever the rate value holds.

Writing a new rate value restarts the division.

Top module: `tbase_prescaler`

## Requirements
- R1: The rate value (`rate_o`) is loaded during reset with 4'b0101 when `fast_mode_i` is 0 (compatibility mode) and with 4'b0000 when `fast_mode_i` is 1 (fast mode).
- R2: `tick_o` is high for exactly one cycle in every `rate_o`+1 cycles. After reset is released, the first strobe comes in the `rate_o`-th cycle; it is high in every cycle when `rate_o` is 0.
- R3: A cycle with `rate_we_i` high loads `rate_wdata_i` into `rate_o` at the next edge and restarts the division. The next strobe is high exactly `rate_wdata_i` cycles after that edge. A strobe already due in the write cycle is still emitted in that cycle.
- R4: `t2_tick_o` is 1 in every cycle while `t2_direct_i` is 1, and equals `tick_o` while `t2_direct_i` is 0.
- R5: In compatibility mode, `samp_o` equals `tick_o`, and `pin_lvl_o` and `pin_fall_o` update only at the edge that ends a cycle with `samp_o` high.
- R6: In fast mode, `samp_o` is 1 in every cycle for any rate value.
- R7: When every cycle is sampled, a new level on `pin_i` shows on `pin_lvl_o` after the third rising edge from the edge at which the new level is first present at the pin, never earlier.
- R8: `pin_fall_o[k]` goes high for one cycle when the new sample of pin k is 0 and its previous sample was 1. A rising level never raises it.
- R9: A change of `fast_mode_i` outside reset has no effect on `rate_o`, on `samp_o` or on the strobe rate until the next reset.
- R10: During reset `pin_lvl_o` is all ones and `pin_fall_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_mode_i | input | 1 | Operating mode, captured only during reset (1 = fast, 0 = compatibility) |
| rate_we_i | input | 1 | Rate value write enable |
| rate_wdata_i | input | 4 | New rate value (division = value + 1) |
| t2_direct_i | input | 1 | Timer 2 in clock-out or baud mode: bypass the prescaler |
| pin_i | input | 6 | External pins, asynchronous: [0..2] counter inputs, [3] capture input, [4..5] interrupt requests |
| tick_o | output | 1 | Shared count-enable strobe for the timers and the watchdog |
| t2_tick_o | output | 1 | Count enable for timer 2 |
| samp_o | output | 1 | Pin sample strobe |
| rate_o | output | 4 | Current rate value |
| pin_lvl_o | output | 6 | Last sampled level of each pin |
| pin_fall_o | output | 6 | One-cycle falling-edge flag for each pin |

## Verification
Two events can land in the same cycle: a rate write and a strobe that the old count has just reached. The bench lets the count reach its terminal value and writes a new rate in that very cycle. It expects the strobe to stay high in that cycle and the next strobe to come exactly the new value's number of cycles after the write edge. A second collision happens in compatibility mode, where a pin's synchronised falling level waits for the strobe. The bench sets a long rate, holds the pin low across the wait and checks that the level and the edge flag change exactly at the strobe edge and not one cycle before.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic {
        MODE_COMPAT = 1'b0,
        MODE_FAST   = 1'b1
    } tbp_mode_e;

    localparam int unsigned TBP_RATE_W      = 4;
    localparam int unsigned TBP_COMPAT_RATE = 5;
    localparam int unsigned TBP_FAST_RATE   = 0;

endpackage

// File: rtl/tbp_divider.sv
module tbp_divider
    import tbp_pkg::*;
#(
    parameter int unsigned RATE_W      = TBP_RATE_W,
    parameter int unsigned COMPAT_RATE = TBP_COMPAT_RATE,
    parameter int unsigned FAST_RATE   = TBP_FAST_RATE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode_i,
    input  logic              we_i,
    input  logic [RATE_W-1:0] wdata_i,
    output logic [RATE_W-1:0] rate_o,
    output logic              tick_o,
    output tbp_mode_e         mode_o
);

    localparam logic [RATE_W-1:0] RST_COMPAT = RATE_W'(COMPAT_RATE);
    localparam logic [RATE_W-1:0] RST_FAST   = RATE_W'(FAST_RATE);

    typedef struct packed {
        tbp_mode_e         mode;
        logic [RATE_W-1:0] rate;
        logic [RATE_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       tick_d;

    always_comb begin
        st_d   = st_q;
        tick_d = (st_q.cnt == st_q.rate);
        if (!rst_n) begin
            st_d.mode = fast_mode_i ? MODE_FAST : MODE_COMPAT;
            st_d.rate = fast_mode_i ? RST_FAST : RST_COMPAT;
            st_d.cnt  = '0;
        end else if (we_i) begin
            st_d.rate = wdata_i;
            st_d.cnt  = '0;
        end else if (tick_d) begin
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rate_o = st_q.rate;
    assign tick_o = tick_d;
    assign mode_o = st_q.mode;

    // R2: a strobe never lasts two cycles unless the rate is zero
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (st_q.rate != '0) && !we_i) |=> !tick_o);

    // R3: a write restarts the count and loads the new rate
    assert_write_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((st_q.cnt == '0) && (rate_o == $past(wdata_i))));

    // R9: the mode is frozen outside reset
    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_o));

endmodule

// File: rtl/tbp_sync.sv
module tbp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic meta;
        logic stable;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        if (!rst_n) begin
            st_d.meta   = 1'b1;
            st_d.stable = 1'b1;
        end else begin
            st_d.meta   = async_i;
            st_d.stable = st_q.meta;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/tbp_sampler.sv
module tbp_sampler #(
    parameter int unsigned N_PINS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_i,
    input  logic [N_PINS-1:0] pin_s_i,
    output logic [N_PINS-1:0] lvl_o,
    output logic [N_PINS-1:0] fall_o
);

    typedef struct packed {
        logic [N_PINS-1:0] lvl;
        logic [N_PINS-1:0] fall;
    } samp_state_t;

    samp_state_t st_d, st_q;

    always_comb begin
        st_d.lvl  = st_q.lvl;
        st_d.fall = '0;
        if (!rst_n) begin
            st_d.lvl  = '1;
            st_d.fall = '0;
        end else if (samp_i) begin
            st_d.lvl  = pin_s_i;
            st_d.fall = st_q.lvl & ~pin_s_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lvl_o  = st_q.lvl;
    assign fall_o = st_q.fall;

    // R5: levels hold between sample strobes
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_i |=> $stable(lvl_o));

    // R8: no edge flag without a sample strobe
    assert_fall_needs_samp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_i |=> (fall_o == '0));

    // R8: a flagged pin always shows a low level
    assert_fall_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_o & lvl_o) == '0));

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
    import tbp_pkg::*;
#(
    parameter int unsigned N_PINS      = 6,
    parameter int unsigned RATE_W      = TBP_RATE_W,
    parameter int unsigned COMPAT_RATE = TBP_COMPAT_RATE,
    parameter int unsigned FAST_RATE   = TBP_FAST_RATE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode_i,
    input  logic              rate_we_i,
    input  logic [RATE_W-1:0] rate_wdata_i,
    input  logic              t2_direct_i,
    input  logic [N_PINS-1:0] pin_i,
    output logic              tick_o,
    output logic              t2_tick_o,
    output logic              samp_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [N_PINS-1:0] pin_lvl_o,
    output logic [N_PINS-1:0] pin_fall_o
);

    tbp_mode_e         mode;
    logic              tick;
    logic [N_PINS-1:0] pin_s;

    tbp_divider #(
        .RATE_W      (RATE_W),
        .COMPAT_RATE (COMPAT_RATE),
        .FAST_RATE   (FAST_RATE)
    ) i_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast_mode_i (fast_mode_i),
        .we_i        (rate_we_i),
        .wdata_i     (rate_wdata_i),
        .rate_o      (rate_o),
        .tick_o      (tick),
        .mode_o      (mode)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        tbp_sync i_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pin_i[g]),
            .sync_o  (pin_s[g])
        );
    end

    assign tick_o    = tick;
    assign t2_tick_o = t2_direct_i | tick;
    assign samp_o    = (mode == MODE_FAST) | tick;

    tbp_sampler #(
        .N_PINS  (N_PINS)
    ) i_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_i  (samp_o),
        .pin_s_i (pin_s),
        .lvl_o   (pin_lvl_o),
        .fall_o  (pin_fall_o)
    );

    // R4: timer 2 is never slower than the shared strobe
    assert_t2_covers_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> t2_tick_o);

endmodule

// File: tb/test_tbase_prescaler.sv
module test_tbase_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_mode = 1'b0;
    logic       rate_we = 1'b0;
    logic [3:0] rate_wdata = 4'd0;
    logic       t2_direct = 1'b0;
    logic [5:0] pin = 6'h3f;
    logic       tick, t2_tick, samp;
    logic [3:0] rate;
    logic [5:0] lvl, fall;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tbase_prescaler i_tbase_prescaler (
        .clk          (clk),
        .rst_n        (rst_n),
        .fast_mode_i  (fast_mode),
        .rate_we_i    (rate_we),
        .rate_wdata_i (rate_wdata),
        .t2_direct_i  (t2_direct),
        .pin_i        (pin),
        .tick_o       (tick),
        .t2_tick_o    (t2_tick),
        .samp_o       (samp),
        .rate_o       (rate),
        .pin_lvl_o    (lvl),
        .pin_fall_o   (fall)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic fm);
        rst_n = 1'b0; fast_mode = fm; rate_we = 1'b0;
        t2_direct = 1'b0; pin = 6'h3f;
        step(); step();
        chk("R1 reset rate", int'(rate), fm ? 0 : 5);
        chk("R10 reset level", int'(lvl), 63);
        chk("R10 reset fall", int'(fall), 0);
        rst_n = 1'b1;
    endtask

    task automatic write_rate(input logic [3:0] v);
        rate_we = 1'b1; rate_wdata = v;
        step();
        rate_we = 1'b0;
    endtask

    task automatic t_reset_defaults();
        do_reset(1'b0);
        do_reset(1'b1);
    endtask

    task automatic t_period_compat();
        do_reset(1'b0);
        for (int i = 1; i <= 11; i++) begin
            step();
            chk("R2 compat period", int'(tick), (i == 5 || i == 11) ? 1 : 0);
            chk("R5 samp equals tick", int'(samp), int'(tick));
        end
    endtask

    task automatic t_fast_every();
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R2 rate zero every cycle", int'(tick), 1);
        end
    endtask

    task automatic t_write_restart();
        do_reset(1'b0);
        step(); step(); step();
        write_rate(4'd3);
        chk("R3 rate loaded", int'(rate), 3);
        chk("R3 no strobe after write", int'(tick), 0);
        for (int i = 1; i <= 4; i++) begin
            step();
            chk("R3 restart timing", int'(tick), (i == 3) ? 1 : 0);
        end
    endtask

    task automatic t_write_on_tick();
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) step();
        rate_we = 1'b1; rate_wdata = 4'd2;
        chk("R3 strobe kept in write cycle", int'(tick), 1);
        step();
        rate_we = 1'b0;
        chk("R3 restart after collision", int'(tick), 0);
        step();
        chk("R3 restart after collision", int'(tick), 0);
        step();
        chk("R3 new strobe after collision", int'(tick), 1);
    endtask

    task automatic t_t2_bypass();
        do_reset(1'b0);
        t2_direct = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R4 bypass high", int'(t2_tick), 1);
        end
        t2_direct = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R4 follows tick", int'(t2_tick), int'(tick));
        end
    endtask

    task automatic t_compat_sample();
        do_reset(1'b0);
        pin[0] = 1'b0;
        write_rate(4'd15);
        for (int i = 1; i <= 15; i++) step();
        chk("R5 strobe pending", int'(samp), 1);
        chk("R5 level held until strobe", int'(lvl[0]), 1);
        step();
        chk("R5 level sampled on strobe", int'(lvl[0]), 0);
        chk("R8 fall flagged", int'(fall[0]), 1);
        step();
        chk("R8 fall one cycle", int'(fall[0]), 0);
    endtask

    task automatic t_fast_sample();
        int n;
        do_reset(1'b1);
        write_rate(4'd15);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            n += int'(samp);
        end
        chk("R6 fast samples every cycle", n, 20);
        pin[1] = 1'b0;
        step(); step();
        chk("R7 not before third edge", int'(lvl[1]), 1);
        step();
        chk("R7 level at third edge", int'(lvl[1]), 0);
        chk("R8 fall flagged fast", int'(fall[1]), 1);
        chk("R8 other pins quiet", int'(fall & 6'h3d), 0);
        step();
        chk("R8 fall one cycle fast", int'(fall[1]), 0);
        pin[1] = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            step();
            chk("R8 no flag on rise", int'(fall[1]), 0);
        end
        chk("R7 rise seen", int'(lvl[1]), 1);
    endtask

    task automatic t_mode_frozen();
        int n;
        do_reset(1'b0);
        fast_mode = 1'b1;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            step();
            n += int'(samp);
        end
        chk("R9 samp unchanged by mode input", n, 2);
        chk("R9 rate unchanged by mode input", int'(rate), 5);
        do_reset(1'b1);
        step();
        chk("R9 mode taken at reset", int'(samp), 1);
    endtask

    initial begin
        t_reset_defaults();
        t_period_compat();
        t_fast_every();
        t_write_restart();
        t_write_on_tick();
        t_t2_bypass();
        t_compat_sample();
        t_fast_sample();
        t_mode_frozen();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule